// File: doc/BRIEF.md
# All-Digital NCO Phase-Locked Loop

This block locks a numerically controlled oscillator to a slow reference pulse train. The reference runs anywhere from 200 Hz to 200 kHz, and the block runs on a much faster system clock. The oscillator is a phase accumulator. Its most significant bit is the recovered clock.

Each rising edge of the reference is synchronised to the system clock. On that edge the accumulator phase is sampled as a signed error around zero phase. The error goes through a short moving-average filter. The filtered error, multiplied by a power-of-two gain, is then subtracted from the increment word. The increment word is clamped to a programmed range.

The gain comes from a left shift. One shift amount applies while the loop is acquiring and a second, smaller one applies once lock is declared. Both are inputs, so a test setup can raise them to reach lock quickly. An optional adaptive mode adds extra shift steps when the filtered error is large. A hysteretic detector compares each edge's error magnitude against a threshold and raises or drops the lock flag.

Top module: `nco_pll`

## Requirements
- R1: While reset is asserted, the following values are loaded:
  - the accumulator is zero, so `clk_out` is 0;
  - `inc_word` is the nominal increment (33554 by default);
  - `phase_err` is 0, the filter history is cleared and `locked` is 0.
- R2: In every clock cycle out of reset, the accumulator (24 bits by default) adds `inc_word` modulo its width. `clk_out` is its most significant bit.
- R3: `ref_in` passes through a two-flop synchronizer and rising-edge detection. An edge first captured at clock k is detected in the cycle after clock k+1. The error is taken from the accumulator value held in that cycle and appears on `phase_err` after the next clock.
- R4: The phase error is the top ERR_W (12 by default) bits of the accumulator, read as a two's-complement number.
- R5: The filtered error is the sum of the four most recent error samples, arithmetically shifted right by two (rounding toward minus infinity).
- R6: One clock after `phase_err` updates, `inc_word` becomes `inc_word - (filtered << s)`. The base shift s is `trk_shift` while `locked` is 1 and `acq_shift` otherwise, where `locked` is the value held before this update.
- R7: When `adapt_en` is 1, s gains one extra step if the filtered magnitude is at least 32 and another if it is at least 256. The total shift is limited to 15.
- R8: The updated increment is clamped to the range 67 to 67109 inclusive and never wraps.
- R9: `locked` rises on the update of the 8th consecutive edge whose error magnitude is below `lock_thresh`.
- R10: `locked` falls on the update of the 4th consecutive edge whose error magnitude is at or above `lock_thresh`.
- R11: Between reference edges, `inc_word`, `phase_err` and `locked` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Asynchronous reference pulse |
| acq_shift | input | 4 | Gain shift used before lock |
| trk_shift | input | 4 | Gain shift used after lock |
| adapt_en | input | 1 | Enables error-dependent extra shift |
| lock_thresh | input | 12 | Error magnitude limit for lock counting |
| clk_out | output | 1 | Recovered clock, accumulator MSB |
| inc_word | output | 24 | Current oscillator increment |
| phase_err | output | 12 | Last sampled signed phase error |
| locked | output | 1 | Lock indication |

## Verification
The stimulus uses four reference patterns:
- A near-nominal period with a permissive threshold shows that lock is reached exactly on the eighth good edge.
- A zero threshold separates the four-edge release from the eight-edge acquisition.
- A much faster reference with maximum gain and adaptive shift drives the increment into its clamp, which tests saturation against wrap-around.
- A slightly slow reference with a mid threshold and a low tracking gain exercises the switch between acquisition and tracking gain.

Every detected edge is compared against an independent transaction model. The model checks the sampled error, the new increment, the lock flag and the recovered clock.

// File: rtl/pll_pkg.sv
package pll_pkg;
   typedef enum logic {
      PH_ACQ = 1'b0,
      PH_TRK = 1'b1
   } loop_phase_e;
endpackage

// File: rtl/pll_ref_sync.sv
module pll_ref_sync #(
   parameter int SYNC_N = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_async,
   output logic edge_o
);
   logic [SYNC_N-1:0] sync_q;
   logic              prev_q;

   if (SYNC_N < 2) begin : g_bad_sync
      $error("pll_ref_sync: SYNC_N must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_N-2:0], ref_async};
         prev_q <= sync_q[SYNC_N-1];
      end
   end

   assign edge_o = sync_q[SYNC_N-1] & ~prev_q;
endmodule

// File: rtl/pll_phase_filt.sv
module pll_phase_filt #(
   parameter int ACC_W    = 24,
   parameter int ERR_W    = 12,
   parameter int AVG_LOG2 = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    edge_i,
   input  logic [ACC_W-1:0]        acc_i,
   output logic [ERR_W-1:0]        err_o,
   output logic signed [ERR_W-1:0] avg_o,
   output logic                    vld_o
);
   localparam int DEPTH = 1 << AVG_LOG2;
   localparam int SUM_W = ERR_W + AVG_LOG2;

   logic signed [ERR_W-1:0] sample;
   logic signed [ERR_W-1:0] taps_q [DEPTH];
   logic signed [SUM_W-1:0] sum_q;
   logic signed [SUM_W-1:0] sample_x;
   logic signed [SUM_W-1:0] oldest_x;
   logic signed [SUM_W-1:0] avg_full;

   if (ERR_W > ACC_W) begin : g_bad_err
      $error("pll_phase_filt: ERR_W must not exceed ACC_W");
   end

   assign sample   = $signed(acc_i[ACC_W-1 -: ERR_W]);
   assign sample_x = $signed({{AVG_LOG2{sample[ERR_W-1]}}, sample});
   assign oldest_x = $signed({{AVG_LOG2{taps_q[DEPTH-1][ERR_W-1]}}, taps_q[DEPTH-1]});

   always_ff @(posedge clk) begin
      if (rst) begin
         taps_q[0] <= '0;
      end else if (edge_i) begin
         taps_q[0] <= sample;
      end
   end

   for (genvar i = 1; i < DEPTH; i++) begin : g_tap
      always_ff @(posedge clk) begin
         if (rst) begin
            taps_q[i] <= '0;
         end else if (edge_i) begin
            taps_q[i] <= taps_q[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_q <= '0;
         err_o <= '0;
         vld_o <= 1'b0;
      end else begin
         vld_o <= edge_i;
         if (edge_i) begin
            sum_q <= sum_q + sample_x - oldest_x;
            err_o <= sample;
         end
      end
   end

   assign avg_full = sum_q >>> AVG_LOG2;
   assign avg_o    = avg_full[ERR_W-1:0];
endmodule

// File: rtl/pll_gain_step.sv
module pll_gain_step
   import pll_pkg::*;
#(
   parameter int          INC_W       = 24,
   parameter int          ERR_W       = 12,
   parameter int          SH_W        = 4,
   parameter int          ADAPT_STEPS = 2,
   parameter int          ADAPT_SPAN  = 3,
   parameter int unsigned INC_MIN     = 67,
   parameter int unsigned INC_MAX     = 67109
) (
   input  logic signed [ERR_W-1:0] avg_i,
   input  logic [INC_W-1:0]        inc_i,
   input  logic                    locked_i,
   input  logic [SH_W-1:0]         acq_sh_i,
   input  logic [SH_W-1:0]         trk_sh_i,
   input  logic                    adapt_en_i,
   output logic [INC_W-1:0]        inc_nxt_o
);
   localparam int SH_MAX = (1 << SH_W) - 1;
   localparam int CNT_W  = SH_W + 2;
   localparam int BIG_W  = (ERR_W + SH_MAX > INC_W) ? ERR_W + SH_MAX : INC_W;
   localparam int NX_W   = BIG_W + 2;

   if (ADAPT_STEPS > SH_MAX || ERR_W - 1 - ADAPT_STEPS * ADAPT_SPAN < 0) begin : g_bad_adapt
      $error("pll_gain_step: adaptive step settings out of range");
   end
   if (INC_MIN > INC_MAX) begin : g_bad_range
      $error("pll_gain_step: INC_MIN above INC_MAX");
   end

   loop_phase_e              phase;
   logic signed [ERR_W:0]    avg_x;
   logic [ERR_W:0]           mag;
   logic [CNT_W-1:0]         extra;
   logic [CNT_W-1:0]         sh_raw;
   logic [SH_W-1:0]          base_sh;
   logic [SH_W-1:0]          sh;
   logic signed [NX_W-1:0]   avg_w;
   logic signed [NX_W-1:0]   cur_w;
   logic signed [NX_W-1:0]   nxt_w;
   logic signed [NX_W-1:0]   lo_w;
   logic signed [NX_W-1:0]   hi_w;

   assign phase   = locked_i ? PH_TRK : PH_ACQ;
   assign base_sh = (phase == PH_TRK) ? trk_sh_i : acq_sh_i;
   assign avg_x   = $signed({avg_i[ERR_W-1], avg_i});
   assign mag     = (avg_x < 0) ? $unsigned(-avg_x) : $unsigned(avg_x);

   if (ADAPT_STEPS > 0) begin : g_adapt
      logic [ADAPT_STEPS-1:0] step_hit;
      for (genvar k = 0; k < ADAPT_STEPS; k++) begin : g_step
         localparam int LIM_EXP = ERR_W - 1 - (k + 1) * ADAPT_SPAN;
         assign step_hit[k] = (mag >= (ERR_W+1)'(1 << LIM_EXP));
      end
      always_comb begin
         extra = '0;
         for (int k = 0; k < ADAPT_STEPS; k++) begin
            extra = extra + CNT_W'(step_hit[k]);
         end
      end
   end else begin : g_fixed
      assign extra = '0;
   end

   always_comb begin
      sh_raw = {2'b00, base_sh} + (adapt_en_i ? extra : '0);
      sh     = (sh_raw > CNT_W'(SH_MAX)) ? SH_W'(SH_MAX) : sh_raw[SH_W-1:0];
   end

   assign avg_w = $signed({{(NX_W-ERR_W){avg_i[ERR_W-1]}}, avg_i});
   assign cur_w = $signed({{(NX_W-INC_W){1'b0}}, inc_i});
   assign lo_w  = $signed(NX_W'(INC_MIN));
   assign hi_w  = $signed(NX_W'(INC_MAX));
   assign nxt_w = cur_w - (avg_w <<< sh);

   always_comb begin
      if (nxt_w < lo_w) begin
         inc_nxt_o = INC_W'(INC_MIN);
      end else if (nxt_w > hi_w) begin
         inc_nxt_o = INC_W'(INC_MAX);
      end else begin
         inc_nxt_o = nxt_w[INC_W-1:0];
      end
   end
endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det #(
   parameter int ERR_W    = 12,
   parameter int LOCK_N   = 8,
   parameter int UNLOCK_N = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             vld_i,
   input  logic [ERR_W-1:0] err_i,
   input  logic [ERR_W-1:0] thresh_i,
   output logic             locked_o
);
   localparam int CNT_MAX = (LOCK_N > UNLOCK_N) ? LOCK_N : UNLOCK_N;
   localparam int CW      = $clog2(CNT_MAX + 1);

   if (LOCK_N < 1 || UNLOCK_N < 1) begin : g_bad_cnt
      $error("pll_lock_det: run lengths must be at least 1");
   end

   logic signed [ERR_W:0] err_x;
   logic [ERR_W:0]        mag;
   logic                  good;
   logic [CW-1:0]         good_q;
   logic [CW-1:0]         bad_q;

   assign err_x = $signed({err_i[ERR_W-1], err_i});
   assign mag   = (err_x < 0) ? $unsigned(-err_x) : $unsigned(err_x);
   assign good  = (mag < {1'b0, thresh_i});

   always_ff @(posedge clk) begin
      if (rst) begin
         good_q   <= '0;
         bad_q    <= '0;
         locked_o <= 1'b0;
      end else if (vld_i) begin
         if (good) begin
            bad_q <= '0;
            if (int'(good_q) < LOCK_N) good_q <= good_q + 1'b1;
            if (!locked_o && int'(good_q) + 1 >= LOCK_N) locked_o <= 1'b1;
         end else begin
            good_q <= '0;
            if (int'(bad_q) < UNLOCK_N) bad_q <= bad_q + 1'b1;
            if (locked_o && int'(bad_q) + 1 >= UNLOCK_N) locked_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/nco_pll.sv
module nco_pll #(
   parameter int          ACC_W       = 24,
   parameter int          ERR_W       = 12,
   parameter int          SH_W        = 4,
   parameter int          SYNC_N      = 2,
   parameter int          AVG_LOG2    = 2,
   parameter int          ADAPT_STEPS = 2,
   parameter int          ADAPT_SPAN  = 3,
   parameter int          LOCK_N      = 8,
   parameter int          UNLOCK_N    = 4,
   parameter int unsigned INC_NOM     = 33554,
   parameter int unsigned INC_MIN     = 67,
   parameter int unsigned INC_MAX     = 67109
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ref_in,
   input  logic [SH_W-1:0]  acq_shift,
   input  logic [SH_W-1:0]  trk_shift,
   input  logic             adapt_en,
   input  logic [ERR_W-1:0] lock_thresh,
   output logic             clk_out,
   output logic [ACC_W-1:0] inc_word,
   output logic [ERR_W-1:0] phase_err,
   output logic             locked
);
   if (ACC_W > 32 || ERR_W > ACC_W || ERR_W < 2) begin : g_bad_w
      $error("nco_pll: width parameters out of range");
   end
   if (INC_NOM < INC_MIN || INC_NOM > INC_MAX) begin : g_bad_nom
      $error("nco_pll: nominal increment outside clamp range");
   end
   if (ACC_W < 32) begin : g_chk_max
      if (longint'(INC_MAX) >= (longint'(1) << ACC_W)) begin : g_bad_max
         $error("nco_pll: INC_MAX does not fit the accumulator");
      end
   end

   logic                    edge_det;
   logic                    flt_vld;
   logic [ACC_W-1:0]        acc_q;
   logic [ACC_W-1:0]        inc_q;
   logic [ACC_W-1:0]        inc_nxt;
   logic signed [ERR_W-1:0] avg;

   pll_ref_sync #(.SYNC_N(SYNC_N)) u_sync (
      .clk       (clk),
      .rst       (rst),
      .ref_async (ref_in),
      .edge_o    (edge_det)
   );

   pll_phase_filt #(.ACC_W(ACC_W), .ERR_W(ERR_W), .AVG_LOG2(AVG_LOG2)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .edge_i (edge_det),
      .acc_i  (acc_q),
      .err_o  (phase_err),
      .avg_o  (avg),
      .vld_o  (flt_vld)
   );

   pll_gain_step #(
      .INC_W(ACC_W), .ERR_W(ERR_W), .SH_W(SH_W),
      .ADAPT_STEPS(ADAPT_STEPS), .ADAPT_SPAN(ADAPT_SPAN),
      .INC_MIN(INC_MIN), .INC_MAX(INC_MAX)
   ) u_gain (
      .avg_i      (avg),
      .inc_i      (inc_q),
      .locked_i   (locked),
      .acq_sh_i   (acq_shift),
      .trk_sh_i   (trk_shift),
      .adapt_en_i (adapt_en),
      .inc_nxt_o  (inc_nxt)
   );

   pll_lock_det #(.ERR_W(ERR_W), .LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)) u_lock (
      .clk      (clk),
      .rst      (rst),
      .vld_i    (flt_vld),
      .err_i    (phase_err),
      .thresh_i (lock_thresh),
      .locked_o (locked)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         inc_q <= ACC_W'(INC_NOM);
      end else begin
         acc_q <= acc_q + inc_q;
         if (flt_vld) inc_q <= inc_nxt;
      end
   end

   assign clk_out  = acc_q[ACC_W-1];
   assign inc_word = inc_q;
endmodule

// File: rtl/nco_pll_chk.sv
module nco_pll_chk #(
   parameter int          ACC_W   = 24,
   parameter int          ERR_W   = 12,
   parameter int unsigned INC_NOM = 33554,
   parameter int unsigned INC_MIN = 67,
   parameter int unsigned INC_MAX = 67109
) (
   input logic             clk,
   input logic             rst,
   input logic             edge_det,
   input logic             flt_vld,
   input logic             clk_out,
   input logic [ACC_W-1:0] inc_word,
   input logic [ERR_W-1:0] phase_err,
   input logic             locked
);
   logic rst_q = 1'b0;
   always_ff @(posedge clk) rst_q <= rst;

   // R1: state after a reset cycle
   always @(negedge clk) begin
      if (rst_q && rst) begin
         a_r1_reset_state: assert (inc_word == ACC_W'(INC_NOM) && !locked
                                   && phase_err == '0 && !clk_out)
            else $error("reset state wrong");
      end
   end

   a_r3_update_after_edge: assert property (@(posedge clk) disable iff (rst)
      flt_vld |-> $past(edge_det));

   a_r8_inc_in_range: assert property (@(posedge clk) disable iff (rst)
      (inc_word >= ACC_W'(INC_MIN)) && (inc_word <= ACC_W'(INC_MAX)));

   a_r9_lock_rise_on_update: assert property (@(posedge clk) disable iff (rst)
      $rose(locked) |-> $past(flt_vld));

   a_r10_lock_fall_on_update: assert property (@(posedge clk) disable iff (rst)
      $fell(locked) |-> $past(flt_vld));

   a_r11_inc_hold: assert property (@(posedge clk) disable iff (rst)
      !flt_vld |=> $stable(inc_word));

   a_r11_err_hold: assert property (@(posedge clk) disable iff (rst)
      !edge_det |=> $stable(phase_err));
endmodule

bind nco_pll nco_pll_chk #(
   .ACC_W(ACC_W), .ERR_W(ERR_W), .INC_NOM(INC_NOM),
   .INC_MIN(INC_MIN), .INC_MAX(INC_MAX)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .edge_det  (edge_det),
   .flt_vld   (flt_vld),
   .clk_out   (clk_out),
   .inc_word  (inc_word),
   .phase_err (phase_err),
   .locked    (locked)
);

// File: tb/nco_pll_tb_top.sv
`timescale 1ns/1ps
module nco_pll_tb_top;
   localparam int NOM = 33554;
   localparam int LO  = 67;
   localparam int HI  = 67109;

   typedef struct {
      logic [11:0] err;
      logic [23:0] inc;
      logic        lock;
      logic        ck;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ref_in = 1'b0;
   logic [3:0]  acq_shift = 4'd2;
   logic [3:0]  trk_shift = 4'd0;
   logic        adapt_en = 1'b0;
   logic [11:0] lock_thresh = 12'd4095;
   logic        clk_out;
   logic [23:0] inc_word;
   logic [11:0] phase_err;
   logic        locked;

   int n_checks = 0;
   int n_fail   = 0;
   int range_bad = 0;
   bit hit_bound = 1'b0;
   bool_t_dummy_unused u_unused_none ();

   item_t sb_q[$];

   // model state
   logic [23:0] m_acc;
   int          m_inc;
   logic        m_s1, m_s2, m_s3, m_vld, m_lock;
   int          m_err;
   int          m_taps[4];
   int          m_good, m_bad;

   always #10 clk = ~clk;

   nco_pll dut_i (
      .clk(clk), .rst(rst), .ref_in(ref_in),
      .acq_shift(acq_shift), .trk_shift(trk_shift),
      .adapt_en(adapt_en), .lock_thresh(lock_thresh),
      .clk_out(clk_out), .inc_word(inc_word),
      .phase_err(phase_err), .locked(locked)
   );

   task automatic check(string tag, longint act, longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // transaction model from the requirements; pushes expected items
   always @(posedge clk) begin
      if (rst) begin
         m_acc = '0; m_inc = NOM; m_s1 = 0; m_s2 = 0; m_s3 = 0;
         m_vld = 0; m_lock = 0; m_err = 0; m_good = 0; m_bad = 0;
         foreach (m_taps[i]) m_taps[i] = 0;
      end else begin
         logic   e;
         logic   old_vld;
         int     old_inc;
         item_t  it;
         e = m_s2 & ~m_s3;
         old_vld = m_vld;
         old_inc = m_inc;
         if (old_vld) begin
            int sum, avg, mag, sh, emag;
            longint nx;
            sum = m_taps[0] + m_taps[1] + m_taps[2] + m_taps[3];
            avg = sum >>> 2;
            mag = (avg < 0) ? -avg : avg;
            sh  = m_lock ? int'(trk_shift) : int'(acq_shift);
            if (adapt_en) sh = sh + (mag >= 32 ? 1 : 0) + (mag >= 256 ? 1 : 0);
            if (sh > 15) sh = 15;
            nx = longint'(old_inc) - longint'(avg) * (longint'(1) << sh);
            if (nx < LO) nx = LO;
            if (nx > HI) nx = HI;
            m_inc = int'(nx);
            emag = (m_err < 0) ? -m_err : m_err;
            if (emag < int'(lock_thresh)) begin
               m_bad = 0; m_good++;
               if (!m_lock && m_good >= 8) m_lock = 1;
            end else begin
               m_good = 0; m_bad++;
               if (m_lock && m_bad >= 4) m_lock = 0;
            end
            it.err = 12'(m_err);
            it.inc = 24'(m_inc);
            it.lock = m_lock;
         end
         if (e) begin
            m_err = int'($signed(m_acc[23:12]));
            m_taps[3] = m_taps[2]; m_taps[2] = m_taps[1];
            m_taps[1] = m_taps[0]; m_taps[0] = m_err;
         end
         m_acc = m_acc + 24'(old_inc);
         m_vld = e;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = ref_in;
         if (old_vld) begin
            it.ck = m_acc[23];
            sb_q.push_back(it);
         end
      end
   end

   // monitor: pops expected items and compares at the falling edge
   always @(negedge clk) begin
      if (!rst) begin
         if (inc_word < 24'(LO) || inc_word > 24'(HI)) range_bad++;
         if (inc_word == 24'(LO) || inc_word == 24'(HI)) hit_bound = 1'b1;
         if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check("R3 R4 phase_err", phase_err, it.err);
            check("R5 R6 R7 R8 inc_word", inc_word, it.inc);
            check("R9 R10 locked", locked, it.lock);
            check("R2 clk_out", clk_out, it.ck);
         end
      end
   end

   task automatic send_ref(int n, int period);
      for (int p = 0; p < n; p++) begin
         @(negedge clk) ref_in = 1'b1;
         repeat (period / 2) @(negedge clk);
         ref_in = 1'b0;
         repeat (period - period / 2 - 1) @(negedge clk);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      logic [23:0] inc_snap;
      logic [11:0] err_snap;
      logic        lock_snap;
      repeat (5) @(negedge clk);
      // R1: reset values
      check("R1 inc_word", inc_word, NOM);
      check("R1 locked", locked, 0);
      check("R1 phase_err", phase_err, 0);
      check("R1 clk_out", clk_out, 0);
      rst = 1'b0;

      // R9: permissive threshold, lock on the 8th edge
      send_ref(7, 500);
      check("R9 no lock after 7 edges", locked, 0);
      send_ref(1, 500);
      check("R9 lock after 8 edges", locked, 1);

      // R10: zero threshold, release on the 4th bad edge
      lock_thresh = 12'd0;
      send_ref(3, 500);
      check("R10 still locked after 3 bad", locked, 1);
      send_ref(1, 500);
      check("R10 unlocked after 4 bad", locked, 0);

      // R8: fast reference, maximum gain with adaptive shift
      acq_shift = 4'd15; adapt_en = 1'b1; lock_thresh = 12'd64;
      send_ref(30, 300);
      check("R8 clamp reached", hit_bound, 1);

      // R6 R7: slow reference, tracking gain lower than acquisition
      acq_shift = 4'd4; trk_shift = 4'd1; lock_thresh = 12'd200;
      send_ref(40, 520);

      // R11: no reference edge, state holds
      inc_snap = inc_word; err_snap = phase_err; lock_snap = locked;
      repeat (200) @(negedge clk);
      check("R11 inc_word held", inc_word, inc_snap);
      check("R11 phase_err held", phase_err, err_snap);
      check("R11 locked held", locked, lock_snap);

      check("R8 range violations", range_bad, 0);
      check("R3 all expected updates seen", sb_q.size(), 0);
      finish_run();
   end
endmodule

module bool_t_dummy_unused;
endmodule